// File: doc/BRIEF.md
# Saturating 40-bit Add/Subtract Result Stage

This block is the result stage of a 40-bit accumulator datapath. The word has a 32-bit signed field with 8 guard bits above it. Each accepted cycle adds or subtracts two 40-bit operands. The stage then judges whether the wrapped 40-bit result still fits the 32-bit two's-complement range, and registers three things: the result, an overflow flag and a selectable condition flag.

A saturation enable chooses how an out-of-range result is handled. With the enable clear, the wrapped result is passed on and the overflow flag is raised. With the enable set, the result is clamped to the limit on the side of its sign, and no overflow is reported at all. Clamping has two formats:
- **Fractional full-word:** the whole 40-bit word is replaced by a limit.
- **Integer upper-halfword:** only bits 39..16 are replaced by a limit, and the low 16 bits of the raw result pass through unchanged.

The condition flag reports one of four things, chosen by a 3-bit selector: carry/borrow, negative, zero or overflow.

Top module: `dsp_sat_stage`

## Requirements
- R1: When `in_valid` is high at a rising edge, `res` takes `opa + opb` (for `op_sub` = 0) or `opa - opb` (for `op_sub` = 1), both modulo 2^40. The new value is visible after that edge, unless R3 to R5 clamp it.
- R2: When `in_valid` is low and `rst` is low at an edge, `res`, `flag_v` and `flag_dc` all keep their previous values.
- R3: The raw result overflows when bits 39..31 are not all equal. This test is the same in both modes. With `sat_en` = 0, `flag_v` is set to this overflow condition and `res` is the wrapped result, unchanged.
- R4: With `sat_en` = 1 and `mode_int` = 0, an overflowing result becomes 40'h007FFFFFFF when raw bit 39 is 0, and 40'hFF80000000 when raw bit 39 is 1.
- R5: With `sat_en` = 1 and `mode_int` = 1, an overflowing result has bits 39..16 set to 24'h007FFF (raw bit 39 = 0) or 24'hFF8000 (raw bit 39 = 1). Bits 15..0 equal the raw result's bits 15..0.
- R6: With `sat_en` = 1, `flag_v` is 0 after every accepted operation.
- R7: `cond_sel` = 3'd3 (overflow mode) makes `flag_dc` equal the overflow condition of R3 gated by `!sat_en`. So `flag_dc` stays 0 whenever `sat_en` = 1.
- R8: `cond_sel` = 3'd0 makes `flag_dc` the carry out of bit 39 for an add, and the borrow (`opa < opb` as unsigned 40-bit values) for a subtract.
- R9: `cond_sel` = 3'd1 makes `flag_dc` bit 39 of the registered `res`. `cond_sel` = 3'd2 sets `flag_dc` when the registered `res` is all zero. Codes 3'd4 to 3'd7 give `flag_dc` = 0.
- R10: A high `rst` at a rising edge clears `res`, `flag_v` and `flag_dc` to 0, whatever `in_valid` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept the operands and controls this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| mode_int | input | 1 | 0 = fractional full-word clamp, 1 = integer upper-halfword clamp |
| sat_en | input | 1 | Saturation enable |
| cond_sel | input | 3 | Condition flag select (0 carry, 1 negative, 2 zero, 3 overflow, 4-7 zero) |
| opa | input | 40 | First operand |
| opb | input | 40 | Second operand |
| res | output | 40 | Registered result |
| flag_v | output | 1 | Registered overflow flag |
| flag_dc | output | 1 | Registered condition flag |

## Verification
The bench works at the exact edges of the 32-bit range. It uses results equal to 0x7FFFFFFF and 0x80000000 (sign-extended), and results one step outside them. A detector that looked only at bit 39, or that skipped bit 31, would miss or invent an overflow there.

Integer-mode saturation is driven with non-zero low halves. A clamp that zeroed or set the low 16 bits would show up at once.

Overflow-mode condition flags are checked with saturation enabled. A design that reported the raw overflow, rather than the suppressed one, would set V or DC where both must stay clear.

Subtract borrow is checked with operands whose signed and unsigned orders differ. A borrow taken from the signed compare would fail there.

// File: rtl/dsp_sat_pkg.sv
package dsp_sat_pkg;
  // Condition-flag selector codes
  localparam logic [2:0] DC_CARRY = 3'd0;
  localparam logic [2:0] DC_NEG   = 3'd1;
  localparam logic [2:0] DC_ZERO  = 3'd2;
  localparam logic [2:0] DC_OVF   = 3'd3;

  typedef struct packed {
    logic v;
    logic dc;
  } sat_flags_t;
endpackage

// File: rtl/dsp_addsub.sv
module dsp_addsub #(
  parameter int W = 40
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cry
);
  localparam int XW = W + 1;

  function automatic logic [XW-1:0] f_addsub(input logic [W-1:0] x, input logic [W-1:0] y,
                                             input logic s);
    logic [XW-1:0] xe, ye;
    xe = {1'b0, x};
    ye = {1'b0, y};
    return s ? (xe - ye) : (xe + ye);
  endfunction

  logic [XW-1:0] wide;
  assign wide = f_addsub(a, b, sub);
  assign sum  = wide[W-1:0];
  assign cry  = wide[XW-1];
endmodule

// File: rtl/dsp_ovf_detect.sv
module dsp_ovf_detect #(
  parameter int W       = 40,
  parameter int FIELD_W = 32
) (
  input  logic [W-1:0] sum,
  output logic         ovf,
  output logic         pos
);
  localparam int TOP_W = W - FIELD_W + 1;

  logic [TOP_W-1:0] top;
  assign top = sum[W-1:FIELD_W-1];

  function automatic logic f_is_sext(input logic [TOP_W-1:0] t);
    return (&t) | ~(|t);
  endfunction

  assign ovf = ~f_is_sext(top);
  assign pos = ~sum[W-1];
endmodule

// File: rtl/dsp_clamp.sv
module dsp_clamp #(
  parameter int W       = 40,
  parameter int FIELD_W = 32,
  parameter int LO_W    = 16
) (
  input  logic [W-1:0] sum,
  input  logic         ovf,
  input  logic         pos,
  input  logic         sat_en,
  input  logic         mode_int,
  output logic [W-1:0] out
);
  localparam int HI_W = W - FIELD_W + 1;
  localparam logic [W-1:0] POS_LIM = {{HI_W{1'b0}}, {(FIELD_W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = ~POS_LIM;

  logic [W-1:0] lim_full;
  logic [W-1:0] lim_sel;
  assign lim_full = pos ? POS_LIM : NEG_LIM;

  generate
    if (LO_W > 0) begin : g_int_fmt
      assign lim_sel = mode_int ? {lim_full[W-1:LO_W], sum[LO_W-1:0]} : lim_full;
    end else begin : g_full_only
      assign lim_sel = lim_full;
    end
  endgenerate

  assign out = (sat_en && ovf) ? lim_sel : sum;
endmodule

// File: rtl/dsp_flag_sel.sv
module dsp_flag_sel #(
  parameter int W = 40
) (
  input  logic [2:0]   cond_sel,
  input  logic         cry,
  input  logic         ovf_eff,
  input  logic [W-1:0] res,
  output logic         dc
);
  import dsp_sat_pkg::*;

  always_comb begin
    case (cond_sel)
      DC_CARRY: dc = cry;
      DC_NEG:   dc = res[W-1];
      DC_ZERO:  dc = ~(|res);
      DC_OVF:   dc = ovf_eff;
      default:  dc = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsp_sat_stage.sv
module dsp_sat_stage #(
  parameter int ACC_W   = 40,
  parameter int FIELD_W = 32,
  parameter int LO_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             op_sub,
  input  logic             mode_int,
  input  logic             sat_en,
  input  logic [2:0]       cond_sel,
  input  logic [ACC_W-1:0] opa,
  input  logic [ACC_W-1:0] opb,
  output logic [ACC_W-1:0] res,
  output logic             flag_v,
  output logic             flag_dc
);
  import dsp_sat_pkg::*;

  // Named internal events (also observed by the bound checker)
  logic [ACC_W-1:0] sum_raw;
  logic             carry_raw;
  logic             ovf_det;
  logic             pos_side;
  logic             ovf_eff;
  logic [ACC_W-1:0] res_next;
  logic             dc_next;
  sat_flags_t       flags_q;

  dsp_addsub #(.W(ACC_W)) u_addsub (
    .a(opa), .b(opb), .sub(op_sub), .sum(sum_raw), .cry(carry_raw)
  );

  dsp_ovf_detect #(.W(ACC_W), .FIELD_W(FIELD_W)) u_ovf (
    .sum(sum_raw), .ovf(ovf_det), .pos(pos_side)
  );

  dsp_clamp #(.W(ACC_W), .FIELD_W(FIELD_W), .LO_W(LO_W)) u_clamp (
    .sum(sum_raw), .ovf(ovf_det), .pos(pos_side), .sat_en(sat_en),
    .mode_int(mode_int), .out(res_next)
  );

  assign ovf_eff = ovf_det & ~sat_en;

  dsp_flag_sel #(.W(ACC_W)) u_flag (
    .cond_sel(cond_sel), .cry(carry_raw), .ovf_eff(ovf_eff),
    .res(res_next), .dc(dc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      flags_q <= '0;
    end else if (in_valid) begin
      res        <= res_next;
      flags_q.v  <= ovf_eff;
      flags_q.dc <= dc_next;
    end
  end

  assign flag_v  = flags_q.v;
  assign flag_dc = flags_q.dc;
endmodule

// File: rtl/dsp_sat_checker.sv
module dsp_sat_checker #(
  parameter int ACC_W   = 40,
  parameter int FIELD_W = 32,
  parameter int LO_W    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             mode_int,
  input logic             sat_en,
  input logic [2:0]       cond_sel,
  input logic [ACC_W-1:0] res,
  input logic             flag_v,
  input logic             flag_dc,
  input logic [ACC_W-1:0] sum_raw,
  input logic             ovf_det
);
  localparam int TOP_W = ACC_W - FIELD_W + 1;

  // R10
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (res == '0 && !flag_v && !flag_dc));

  // R2
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res) && $stable(flag_v) && $stable(flag_dc)));

  // R3
  p_v_tracks_ovf_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sat_en) |=> (flag_v == $past(ovf_det) && res == $past(sum_raw)));

  // R4, R5: a saturated result is always in range
  p_sat_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_en) |=>
      (res[ACC_W-1:FIELD_W-1] == '0 || res[ACC_W-1:FIELD_W-1] == {TOP_W{1'b1}}));

  // R5
  p_int_low_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_en && mode_int) |=> (res[LO_W-1:0] == $past(sum_raw[LO_W-1:0])));

  // R6
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_en) |=> !flag_v);

  // R7
  p_dc_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_en && cond_sel == 3'd3) |=> !flag_dc);

  // R9
  p_dc_unused_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_sel[2]) |=> !flag_dc);
endmodule

bind dsp_sat_stage dsp_sat_checker #(.ACC_W(ACC_W), .FIELD_W(FIELD_W), .LO_W(LO_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mode_int(mode_int), .sat_en(sat_en),
  .cond_sel(cond_sel), .res(res), .flag_v(flag_v), .flag_dc(flag_dc),
  .sum_raw(sum_raw), .ovf_det(ovf_det)
);

// File: tb/tb_dsp_sat_stage.sv
module tb_dsp_sat_stage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        op_sub = 1'b0;
  logic        mode_int = 1'b0;
  logic        sat_en = 1'b0;
  logic [2:0]  cond_sel = 3'd0;
  logic [39:0] opa = '0;
  logic [39:0] opb = '0;
  logic [39:0] res;
  logic        flag_v;
  logic        flag_dc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [39:0] exp_res = '0;
  bit          exp_v = 0;
  bit          exp_dc = 0;
  string       tag_r = "R10", tag_v = "R10", tag_dc = "R10";

  always #4 clk = ~clk;  // 125 MHz

  dsp_sat_stage dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub), .mode_int(mode_int),
    .sat_en(sat_en), .cond_sel(cond_sel), .opa(opa), .opb(opb),
    .res(res), .flag_v(flag_v), .flag_dc(flag_dc)
  );

  // Behavioural reference: integer arithmetic on 64-bit values
  task automatic model(input logic [39:0] a, input logic [39:0] b, input bit sub,
                       input bit mi, input bit s, input logic [2:0] cs);
    longint ua, ub, t, sv;
    bit c, ov;
    logic [39:0] w, r;
    ua = longint'(64'(a));
    ub = longint'(64'(b));
    t  = sub ? ua - ub : ua + ub;
    c  = sub ? (ua < ub) : (t >= 64'h100_0000_0000);
    w  = t[39:0];
    sv = w[39] ? longint'(64'(w)) - 64'h100_0000_0000 : longint'(64'(w));
    ov = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
    r  = w;
    if (s && ov) begin
      if (sv >= 0) r = mi ? {24'h007FFF, w[15:0]} : 40'h007FFFFFFF;
      else         r = mi ? {24'hFF8000, w[15:0]} : 40'hFF80000000;
    end
    exp_res = r;
    exp_v   = ov && !s;
    case (cs)
      3'd0: exp_dc = c;
      3'd1: exp_dc = r[39];
      3'd2: exp_dc = (r == 40'd0);
      3'd3: exp_dc = ov && !s;
      default: exp_dc = 0;
    endcase
    tag_r  = (s && ov) ? (mi ? "R5" : "R4") : (ov ? "R3" : "R1");
    tag_v  = s ? "R6" : "R3";
    tag_dc = (cs == 3'd0) ? "R8" : (cs == 3'd3) ? "R7" : "R9";
  endtask

  task automatic compare();
    checks += 3;
    if (res !== exp_res) begin
      errors++;
      $display("FAIL %s res actual %h expected %h", tag_r, res, exp_res);
    end
    if (flag_v !== exp_v) begin
      errors++;
      $display("FAIL %s flag_v actual %0b expected %0b", tag_v, flag_v, exp_v);
    end
    if (flag_dc !== exp_dc) begin
      errors++;
      $display("FAIL %s flag_dc actual %0b expected %0b", tag_dc, flag_dc, exp_dc);
    end
  endtask

  // One cycle: check what the previous edge produced, then drive the next input
  task automatic step(input bit r, input bit v, input bit sub, input bit mi, input bit s,
                      input logic [2:0] cs, input logic [39:0] a, input logic [39:0] b);
    @(negedge clk);
    compare();
    rst = r; in_valid = v; op_sub = sub; mode_int = mi; sat_en = s;
    cond_sel = cs; opa = a; opb = b;
    if (r) begin
      exp_res = '0; exp_v = 0; exp_dc = 0;
      tag_r = "R10"; tag_v = "R10"; tag_dc = "R10";
    end else if (v) begin
      model(a, b, sub, mi, s, cs);
    end else begin
      tag_r = "R2"; tag_v = "R2"; tag_dc = "R2";
    end
  endtask

  function automatic logic [39:0] pick();
    logic [31:0] x, y;
    x = $urandom;
    y = $urandom;
    case (y % 4)
      0: return {{8{x[31]}}, x};
      1: return {y[7:0], x};
      2: return 40'h007FFFFFF0 + 40'(x % 32);
      default: return 40'hFF80000010 - 40'(x % 32);
    endcase
  endfunction

  initial begin
    // R10 reset state
    step(1, 0, 0, 0, 0, 0, '0, '0);
    step(1, 1, 0, 0, 0, 0, 40'h5, 40'h6);
    // R1 plain add / sub
    step(0, 1, 0, 0, 0, 3'd4, 40'd100, 40'd23);
    step(0, 1, 1, 0, 0, 3'd1, 40'd5, 40'd9);
    // R3 edge of range, no saturation
    step(0, 1, 0, 0, 0, 3'd3, 40'h007FFFFFFE, 40'd1);
    step(0, 1, 0, 0, 0, 3'd3, 40'h007FFFFFFF, 40'd1);
    step(0, 1, 1, 0, 0, 3'd3, 40'hFF80000000, 40'd1);
    // R4 fractional clamp
    step(0, 1, 0, 0, 1, 3'd3, 40'h007FFFFFFF, 40'd1);
    step(0, 1, 1, 0, 1, 3'd3, 40'hFF80000000, 40'd1);
    step(0, 1, 0, 0, 1, 3'd1, 40'h0100000000, 40'h0000001234);
    // R5 integer clamp with low-half passthrough
    step(0, 1, 0, 1, 1, 3'd3, 40'h007FFF1234, 40'h0000015555);
    step(0, 1, 1, 1, 1, 3'd2, 40'hFF80000ABC, 40'h0000020001);
    // R2 hold
    step(0, 0, 0, 0, 0, 3'd0, 40'hFFFFFFFFFF, 40'hFFFFFFFFFF);
    step(0, 0, 1, 1, 1, 3'd2, 40'h1, 40'h1);
    // R8 carry and borrow (signed vs unsigned order differ)
    step(0, 1, 0, 0, 0, 3'd0, 40'hFFFFFFFFFF, 40'd1);
    step(0, 1, 1, 0, 0, 3'd0, 40'd1, 40'hFFFFFFFFFF);
    step(0, 1, 1, 0, 0, 3'd0, 40'hFFFFFFFFFF, 40'd1);
    // R9 zero / negative / unused codes
    step(0, 1, 1, 0, 0, 3'd2, 40'h1234, 40'h1234);
    step(0, 1, 0, 0, 0, 3'd7, 40'hFFFFFFFFFF, 40'd1);
    step(0, 1, 1, 0, 1, 3'd1, 40'd0, 40'd1);
    // Random patterns
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] k;
      k = $urandom;
      step(k[31:27] == 5'd0, k[0] | k[1], k[2], k[3], k[4], k[7:5], pick(), pick());
    end
    step(0, 0, 0, 0, 0, 0, '0, '0);
    @(negedge clk);
    compare();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual not done expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule